// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic Biquad Filter

This block is a single second-order recursive filter section for 8-bit signed samples. It uses no multipliers. Each output comes from two small lookup tables that are scanned one bit-slice at a time. The first table holds every sum that can be formed from the three forward taps. Its 3-bit address is one bit from each of the current input, the previous input and the input before that. The second table holds the negated sums of the two recursive taps. Its 2-bit address is one bit from each of the two previous outputs. Both table words are added into a single shift-accumulator, which starts at the most significant slice and works downwards.

After the last slice the accumulated value is rounded to the output scale and clamped to the 8-bit range. It then leaves the block as the new output and becomes the newest entry of the feedback history. The input history advances in the same step. A caller presents a sample together with a one-cycle strobe. It gets the result back one cycle after the last slice, marked by an output strobe.

Top module: `da_biquad`

## Requirements
- R1: A synchronous active-high reset clears every history register, the accumulator, `yOut` and `outValid` to zero. The first output after reset therefore depends only on the first accepted sample.
- R2: A sample is accepted when `sampleValid` is high on a clock edge while the block is idle. `outValid` is high for exactly one cycle, after the 9th clock edge following the accepting edge (DATA_W+1). A new sample can be accepted on the very next edge after that.
- R3: `sampleValid` is ignored on any edge from the accepting edge up to and including the 9th edge after it. The ignored sample changes neither the outputs nor the stored input or output history.
- R4: With Q1.15 integer taps B0=8136, B1=16276, B2=8136, A1=6036 and A2=5820, the output for sample n is derived from acc = B0·x[n] + B1·x[n−1] + B2·x[n−2] − A1·y[n−1] − A2·y[n−2].
- R5: The output equals floor((acc + 16384) / 32768), which is round to nearest with ties going upward. The result is clamped to the range −128..127.
- R6: `xIn` is two's complement. Negative samples, including −128, are handled exactly, because the sign-bit slice is subtracted.
- R7: `yOut` keeps its value in every cycle in which `outValid` is low.
- R8: The feedback history holds the rounded 8-bit outputs, so an isolated impulse followed by zeros gives a response that matches the quantised recursion exactly as it decays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Strobe: `xIn` holds a new sample |
| xIn | input | 8 | Signed input sample |
| outValid | output | 1 | One-cycle strobe: `yOut` holds a new result |
| yOut | output | 8 | Signed filtered output, held between strobes |

## Verification
Rounding is probed straight after reset, using inputs of ±2 and ±3. Their scaled values fall just below and just above one half. A design that truncates, or that floors negative values, returns a result one step off. A sample of −128 and long negative runs test the sign slice: an accumulator that added the top slice instead of subtracting it would give large positive results. Strobes held high through the whole busy window, plus samples sent back to back at the minimum spacing, catch two faults: a controller that restarts in mid-scan, and one that releases a cycle late. An impulse followed by a long run of zeros, and then random traffic, show whether the feedback table really reads the quantised past outputs; any slip in the history shift shows up in the decay.

// File: rtl/da_biquad_pkg.sv
package da_biquad_pkg;

  parameter int COEF_W    = 16;
  parameter int COEF_FRAC = 15;

  // Q1.15 taps
  parameter int B0 = 8136;
  parameter int B1 = 16276;
  parameter int B2 = 8136;
  parameter int A1 = 6036;
  parameter int A2 = 5820;

  typedef struct packed {
    logic load;      // capture the new sample
    logic accum;     // slice scan active
    logic msbSlice;  // first slice: clear and subtract
    logic finish;    // round, clamp, shift histories
  } ctlT;

endpackage

// File: rtl/da_biquad_ctrl.sv
module da_biquad_ctrl
  import da_biquad_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleValid,
  output ctlT                        ctl,
  output logic [$clog2(DATA_W)-1:0]  bitSel,
  output logic                       busy
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic [IDX_W-1:0] bitIdx;
  logic fin;
  logic idle;

  assign idle = !busy && !fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      fin    <= 1'b0;
      bitIdx <= '0;
    end else begin
      fin <= 1'b0;
      if (idle && sampleValid) begin
        busy   <= 1'b1;
        bitIdx <= TOP_IDX;
      end else if (busy) begin
        if (bitIdx == '0) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          bitIdx <= bitIdx - 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.load     = idle && sampleValid;
    ctl.accum    = busy;
    ctl.msbSlice = busy && (bitIdx == TOP_IDX);
    ctl.finish   = fin;
  end

  assign bitSel = bitIdx;

endmodule

// File: rtl/da_biquad_dp.sv
module da_biquad_dp
  import da_biquad_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  ctlT                              ctl,
  input  logic [$clog2(DATA_W)-1:0]        bitSel,
  input  logic signed [DATA_W-1:0]         xIn,
  output logic                             outValid,
  output logic signed [DATA_W-1:0]         yOut
);

  localparam int ACC_W = DATA_W + COEF_W + 3;
  localparam int FF_N  = 8;
  localparam int FB_N  = 4;
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1 << (COEF_FRAC - 1));
  localparam logic signed [ACC_W-1:0] Y_HI = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_LO = -(ACC_W'(1 << (DATA_W - 1)));

  logic signed [ACC_W-1:0] ffTab [FF_N];
  logic signed [ACC_W-1:0] fbTab [FB_N];

  // forward table: every sum of the three forward taps
  for (genvar i = 0; i < FF_N; i++) begin : g_ff
    localparam int V = (((i & 1) != 0) ? B0 : 0) +
                       (((i & 2) != 0) ? B1 : 0) +
                       (((i & 4) != 0) ? B2 : 0);
    assign ffTab[i] = ACC_W'(V);
  end

  // feedback table: negated sums of the recursive taps
  for (genvar i = 0; i < FB_N; i++) begin : g_fb
    localparam int V = -((((i & 1) != 0) ? A1 : 0) +
                         (((i & 2) != 0) ? A2 : 0));
    assign fbTab[i] = ACC_W'(V);
  end

  logic signed [DATA_W-1:0] xCur, xD1, xD2, yD1, yD2;
  logic signed [ACC_W-1:0]  acc, accNext, term, rounded, quot;
  logic signed [DATA_W-1:0] ySat;
  logic [2:0] ffAddr;
  logic [1:0] fbAddr;

  always_comb begin
    ffAddr  = {xD2[bitSel], xD1[bitSel], xCur[bitSel]};
    fbAddr  = {yD2[bitSel], yD1[bitSel]};
    term    = ffTab[ffAddr] + fbTab[fbAddr];
    accNext = ctl.msbSlice ? -term : ((acc <<< 1) + term);
  end

  always_comb begin
    rounded = acc + HALF_LSB;
    quot    = rounded >>> COEF_FRAC;
    if (quot > Y_HI)      ySat = DATA_W'(Y_HI);
    else if (quot < Y_LO) ySat = DATA_W'(Y_LO);
    else                  ySat = DATA_W'(quot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xCur     <= '0;
      xD1      <= '0;
      xD2      <= '0;
      yD1      <= '0;
      yD2      <= '0;
      acc      <= '0;
      yOut     <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.finish;
      if (ctl.load) xCur <= xIn;
      if (ctl.accum) acc <= accNext;
      if (ctl.finish) begin
        yOut <= ySat;
        yD1  <= ySat;
        yD2  <= yD1;
        xD1  <= xCur;
        xD2  <= xD1;
      end
    end
  end

endmodule

// File: rtl/da_biquad.sv
module da_biquad
  import da_biquad_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] xIn,
  output logic              outValid,
  output logic [DATA_W-1:0] yOut
);

  ctlT ctl;
  logic [$clog2(DATA_W)-1:0] bitSel;
  logic busy;
  logic signed [DATA_W-1:0] yOutS;

  da_biquad_ctrl #(.DATA_W(DATA_W)) ctrlInst (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .ctl(ctl), .bitSel(bitSel), .busy(busy)
  );

  da_biquad_dp #(.DATA_W(DATA_W)) dpInst (
    .clk(clk), .rst(rst), .ctl(ctl), .bitSel(bitSel),
    .xIn($signed(xIn)), .outValid(outValid), .yOut(yOutS)
  );

  assign yOut = yOutS;

endmodule

// File: rtl/da_biquad_chk.sv
module da_biquad_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sampleValid,
  input logic              busy,
  input logic              outValid,
  input logic [DATA_W-1:0] yOut
);

  localparam int SPAN = DATA_W + 1;
  int unsigned cnt;

  // independent count of the cycles since a sample was taken
  always_ff @(posedge clk) begin
    if (rst) cnt <= 0;
    else if (cnt == 0) cnt <= sampleValid ? 1 : 0;
    else if (cnt == SPAN) cnt <= 0;
    else cnt <= cnt + 1;
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);  // R2
  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (rst)
    (cnt == SPAN) |=> outValid);  // R2
  AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(cnt == SPAN));  // R2
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(yOut));  // R7
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != 0));  // R3
  AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (cnt == 0) |-> !busy);  // R3

endmodule

bind da_biquad da_biquad_chk #(.DATA_W(DATA_W)) chkInst (
  .clk(clk), .rst(rst), .sampleValid(sampleValid), .busy(busy),
  .outValid(outValid), .yOut(yOut)
);

// File: tb/da_biquad_test.sv
`timescale 1ns/1ps
module da_biquad_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic [7:0] xIn = 8'd0;
  logic outValid;
  logic [7:0] yOut;

  int nVec = 0;
  int nFail = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit finished = 1'b0;
  string tag = "R1";

  // behavioural model state
  int mCnt = 0;
  int mX = 0;
  int hx1 = 0, hx2 = 0, hy1 = 0, hy2 = 0;
  int expY = 0;
  bit expValid = 1'b0;

  da_biquad uut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .xIn(xIn),
    .outValid(outValid), .yOut(yOut)
  );

  always #5 clk = ~clk;

  function automatic int refOut(int x0, int x1, int x2, int y1, int y2);
    int acc;
    int q;
    acc = 8136 * x0 + 16276 * x1 + 8136 * x2 - 6036 * y1 - 5820 * y2;
    q = (acc + 16384) >>> 15;
    if (q > 127) q = 127;
    if (q < -128) q = -128;
    return q;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mCnt = 0; hx1 = 0; hx2 = 0; hy1 = 0; hy2 = 0;
      expY = 0; expValid = 1'b0;
    end else begin
      expValid = 1'b0;
      if (mCnt == 0) begin
        if (sampleValid) begin
          mCnt = 9;
          mX = int'($signed(xIn));
        end
      end else begin
        mCnt--;
        if (mCnt == 0) begin
          expY = refOut(mX, hx1, hx2, hy1, hy2);
          hy2 = hy1; hy1 = expY;
          hx2 = hx1; hx1 = mX;
          expValid = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !rst && !finished) begin
      nVec++;
      if (outValid !== expValid) begin
        nFail++;
        $display("FAIL R2: outValid=%0b expected %0b at cycle %0d", outValid, expValid, cycles);
      end
      nVec++;
      if (int'($signed(yOut)) != expY) begin
        nFail++;
        $display("FAIL %s: yOut=%0d expected %0d at cycle %0d",
                 expValid ? tag : "R7", $signed(yOut), expY, cycles);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      nFail++;
      $display("FAIL watchdog: run did not end, cycles=%0d expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sendSample(input int x, input int gap);
    @(negedge clk);
    sampleValid = 1'b1;
    xIn = 8'(x);
    @(negedge clk);
    sampleValid = 1'b0;
    xIn = 8'd0;
    repeat (8 + gap) @(negedge clk);
  endtask

  // strobe stays high through the busy window with junk data
  task automatic sendHeld(input int x, input int junk);
    @(negedge clk);
    sampleValid = 1'b1;
    xIn = 8'(x);
    @(negedge clk);
    xIn = 8'(junk);
    repeat (8) @(negedge clk);
    sampleValid = 1'b0;
    xIn = 8'd0;
  endtask

  initial begin
    doReset();
    started = 1'b1;
    // R1: reset state at the ports
    @(negedge clk);
    nVec++;
    if (outValid !== 1'b0 || yOut !== 8'd0) begin
      nFail++;
      $display("FAIL R1: outValid=%0b yOut=%0d expected 0 and 0", outValid, yOut);
    end
    tag = "R1";
    sendSample(100, 0);   // 25 from zero history

    // R5: rounding from a cleared history
    tag = "R5";
    doReset(); sendSample(3, 0);    // +1
    doReset(); sendSample(2, 0);    //  0
    doReset(); sendSample(-2, 0);   //  0
    doReset(); sendSample(-3, 0);   // -1

    // R6: most negative input and negative runs
    tag = "R6";
    doReset();
    for (int i = 0; i < 12; i++) sendSample(-128, 0);
    for (int i = 0; i < 6; i++) sendSample(127, 0);
    sendSample(-128, 0);

    // R8: impulse decay through quantised feedback
    tag = "R8";
    doReset();
    sendSample(127, 0);
    for (int i = 0; i < 20; i++) sendSample(0, i % 3);

    // R3: strobe held during busy, junk must not enter
    tag = "R3";
    for (int i = 0; i < 6; i++) sendHeld(40 - 25 * i, 127 - 50 * i);
    sendSample(0, 0);

    // R4: random traffic with minimum and longer spacing
    tag = "R4";
    for (int i = 0; i < 150; i++) sendSample(int'($signed(8'($urandom))), int'($urandom % 3));

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule